// File: doc/BRIEF.md
# Anti-Rollback Fuse Check Sequencer

This block runs once per boot and stops firmware from being rolled back to an older release. It counts how many fuses are burnt in a one-time-programmable version word. It compares that count with the number that the running firmware release requires for the current unit type. A surplus of burnt fuses means the part has already run newer firmware, so the block stops in a fatal panic.

A shortfall starts a burn sequence. The block raises the programming enable and writes the required thermometer pattern to two redundant fuse offsets. It then drops the enable, leaves a marker byte in a scratch register that survives reset, and asks the watchdog for a reset.

On the boot that follows, the block sees the watchdog reset cause together with the marker. In that case it accepts only an exact count match, and then it pulses a clear of the reset cause. Any other outcome on that boot is a panic.

The states are:

- IDLE waits for `start`.
- CHECK compares the counts and picks the path.
- PGM_ON, WR_LO, WR_HI and PGM_OFF make up the burn.
- MARK writes the marker.
- WDT holds the reset request.
- CLEAR pulses the cause clear.
- DONE and PANIC are terminal.

The transitions are:

- IDLE to CHECK on `start`.
- CHECK to PANIC on a surplus, or on a post-burn mismatch.
- CHECK to CLEAR on a post-burn match.
- CHECK to PGM_ON on a shortfall.
- CHECK to DONE on a plain match.
- PGM_ON, WR_LO, WR_HI, PGM_OFF, MARK and WDT follow one another in that order.
- CLEAR to DONE.

Top module: `rollback_guard`

## Requirements
- R1: While reset is low and in IDLE before `start`, all of `panic`, `done`, `wdt_req`, `pgm_en`, `pgm_req`, `scratch_we` and `cause_clr` are 0.
- R2: For a production unit the required count is 1, 2, 3 or 4 for `ver_idx` 0, 1, 2 or 3.
- R3: `unit_cfg` equal to 0 selects production. Any other value, 3 (debug) included, selects non-production. For non-production the required counts are 0, 0, 1 and 1 for `ver_idx` 0 to 3.
- R4: The burnt count is the number of 1 bits in `fuse_word`, whatever their positions.
- R5: A count above the requirement sends the block to PANIC. `panic` then stays 1 until reset, with no programming, marker or reset request.
- R6: A count below the requirement, without a post-burn boot, raises `pgm_en` one cycle before the first write. It then issues `pgm_req` on two consecutive cycles, to offset 0x3A and then 0x3C, each with `pgm_data` = (1<<required)-1. `pgm_en` falls before the marker is written.
- R7: After programming is disabled, the block writes 0x21 to scratch for exactly one cycle. It then holds `wdt_req` at 1.
- R8: A post-burn boot is one where `rst_cause` equals 1 (watchdog) and `scratch_rd` equals 0x21. On such a boot with a matching count, `cause_clr` pulses for exactly one cycle and `done` then rises.
- R9: On a post-burn boot with a count below the requirement, the block panics without programming and without clearing the cause.
- R10: A matching count on a boot that is not post-burn gives `done` with no `cause_clr` and no programming.
- R11: Once DONE or PANIC is reached, `start` and input changes have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the boot-time check |
| ver_idx | input | 2 | Firmware release index |
| unit_cfg | input | 2 | Unit type field, 0 = production |
| fuse_word | input | FUSE_W | Version fuse word as read |
| rst_cause | input | CAUSE_W | Reset cause, 1 = watchdog |
| scratch_rd | input | SCR_W | Retained scratch register value |
| pgm_en | output | 1 | Fuse programming enabled |
| pgm_req | output | 1 | Fuse write strobe |
| pgm_off | output | OFF_W | Fuse offset for the write |
| pgm_data | output | FUSE_W | Fuse value for the write |
| scratch_we | output | 1 | Scratch write strobe |
| scratch_wdata | output | SCR_W | Scratch write value |
| wdt_req | output | 1 | Watchdog reset request |
| cause_clr | output | 1 | Clear the reset cause |
| panic | output | 1 | Fatal rollback detected |
| done | output | 1 | Check passed |

## Verification
The bench builds the block with its default parameters: a 16-bit fuse word, 8-bit offsets at 0x3A and 0x3C, and an 8-bit marker of 0x21. The 16-bit word lets counts far above the largest requirement drive the panic path. It also lets scattered bit patterns show that the count ignores bit positions. Both unit classes and all four release indices are reachable. Post-burn boots with the marker present and absent are both exercised.

// File: rtl/rbg_pkg.sv
package rbg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PGM_ON,
        ST_WR_LO,
        ST_WR_HI,
        ST_PGM_OFF,
        ST_MARK,
        ST_WDT,
        ST_CLEAR,
        ST_DONE,
        ST_PANIC
    } rbg_state_e;

    // Required burnt-fuse count per release index and unit class.
    function automatic logic [2:0] need_fuses(input logic [1:0] ver, input logic prod);
        if (prod)
            need_fuses = {1'b0, ver} + 3'd1;
        else
            need_fuses = {2'b00, ver[1]};
    endfunction

endpackage

// File: rtl/rbg_popcount.sv
module rbg_popcount #(
    parameter int W     = 16,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] part [W+1];

    assign part[0] = '0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_add
            assign part[g+1] = part[g] + CNT_W'(bits[g]);
        end
    endgenerate

    assign count = part[W];
endmodule

// File: rtl/rbg_expect.sv
module rbg_expect #(
    parameter int FUSE_W   = 16,
    parameter int CNT_W    = $clog2(FUSE_W + 1),
    parameter logic [1:0] PROD_CFG = 2'd0
) (
    input  logic [1:0]        ver_idx,
    input  logic [1:0]        unit_cfg,
    output logic [CNT_W-1:0]  need,
    output logic [FUSE_W-1:0] pattern
);
    import rbg_pkg::*;

    logic       prod;
    logic [2:0] need3;

    assign prod  = (unit_cfg == PROD_CFG);
    assign need3 = need_fuses(ver_idx, prod);
    assign need  = CNT_W'(need3);

    // Thermometer pattern holding exactly need3 burnt fuses.
    always_comb begin
        pattern = '0;
        for (int i = 0; i < FUSE_W; i++)
            pattern[i] = (i < int'(need3));
    end
endmodule

// File: rtl/rollback_guard.sv
module rollback_guard #(
    parameter int FUSE_W   = 16,
    parameter int OFF_W    = 8,
    parameter logic [OFF_W-1:0] OFF_LO = 8'h3A,
    parameter logic [OFF_W-1:0] OFF_HI = 8'h3C,
    parameter int SCR_W    = 8,
    parameter logic [SCR_W-1:0] MAGIC = 8'h21,
    parameter int CAUSE_W  = 2,
    parameter logic [CAUSE_W-1:0] CAUSE_WDT = 2'd1,
    parameter logic [1:0] PROD_CFG = 2'd0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         ver_idx,
    input  logic [1:0]         unit_cfg,
    input  logic [FUSE_W-1:0]  fuse_word,
    input  logic [CAUSE_W-1:0] rst_cause,
    input  logic [SCR_W-1:0]   scratch_rd,
    output logic               pgm_en,
    output logic               pgm_req,
    output logic [OFF_W-1:0]   pgm_off,
    output logic [FUSE_W-1:0]  pgm_data,
    output logic               scratch_we,
    output logic [SCR_W-1:0]   scratch_wdata,
    output logic               wdt_req,
    output logic               cause_clr,
    output logic               panic,
    output logic               done
);
    import rbg_pkg::*;

    localparam int CNT_W = $clog2(FUSE_W + 1);

    rbg_state_e       state, state_nx;
    logic [CNT_W-1:0] burnt;
    logic [CNT_W-1:0] need;
    logic [FUSE_W-1:0] pattern;
    logic             post_burn;

    rbg_popcount #(.W(FUSE_W), .CNT_W(CNT_W)) u_count (
        .bits  (fuse_word),
        .count (burnt)
    );

    rbg_expect #(.FUSE_W(FUSE_W), .CNT_W(CNT_W), .PROD_CFG(PROD_CFG)) u_expect (
        .ver_idx  (ver_idx),
        .unit_cfg (unit_cfg),
        .need     (need),
        .pattern  (pattern)
    );

    assign post_burn = (rst_cause == CAUSE_WDT) && (scratch_rd == MAGIC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (burnt > need)       state_nx = ST_PANIC;
                else if (post_burn)     state_nx = (burnt == need) ? ST_CLEAR : ST_PANIC;
                else if (burnt < need)  state_nx = ST_PGM_ON;
                else                    state_nx = ST_DONE;
            end
            ST_PGM_ON:  state_nx = ST_WR_LO;
            ST_WR_LO:   state_nx = ST_WR_HI;
            ST_WR_HI:   state_nx = ST_PGM_OFF;
            ST_PGM_OFF: state_nx = ST_MARK;
            ST_MARK:    state_nx = ST_WDT;
            ST_WDT:     state_nx = ST_WDT;
            ST_CLEAR:   state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_DONE;
            ST_PANIC:   state_nx = ST_PANIC;
            default:    state_nx = ST_PANIC;
        endcase
    end

    always_comb begin
        pgm_en        = 1'b0;
        pgm_req       = 1'b0;
        pgm_off       = '0;
        pgm_data      = '0;
        scratch_we    = 1'b0;
        scratch_wdata = '0;
        wdt_req       = 1'b0;
        cause_clr     = 1'b0;
        panic         = 1'b0;
        done          = 1'b0;
        unique case (state)
            ST_PGM_ON: pgm_en = 1'b1;
            ST_WR_LO: begin
                pgm_en   = 1'b1;
                pgm_req  = 1'b1;
                pgm_off  = OFF_LO;
                pgm_data = pattern;
            end
            ST_WR_HI: begin
                pgm_en   = 1'b1;
                pgm_req  = 1'b1;
                pgm_off  = OFF_HI;
                pgm_data = pattern;
            end
            ST_MARK: begin
                scratch_we    = 1'b1;
                scratch_wdata = MAGIC;
            end
            ST_WDT:   wdt_req   = 1'b1;
            ST_CLEAR: cause_clr = 1'b1;
            ST_DONE:  done      = 1'b1;
            ST_PANIC: panic     = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rollback_guard_chk.sv
module rollback_guard_chk #(
    parameter int OFF_W = 8,
    parameter logic [OFF_W-1:0] OFF_LO = 8'h3A,
    parameter logic [OFF_W-1:0] OFF_HI = 8'h3C
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pgm_en,
    input logic             pgm_req,
    input logic [OFF_W-1:0] pgm_off,
    input logic             scratch_we,
    input logic             wdt_req,
    input logic             cause_clr,
    input logic             panic,
    input logic             done
);
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> !(panic || done || wdt_req || pgm_en || pgm_req || scratch_we || cause_clr));

    a_r5_panic_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        panic |=> panic);

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({panic, done, wdt_req}));

    a_r6_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |-> pgm_en);

    a_r6_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && pgm_off == OFF_LO) |=> (pgm_req && pgm_off == OFF_HI));

    a_r7_marker_unprogrammed: assert property (@(posedge clk) disable iff (!rst_n)
        scratch_we |-> !pgm_en);

    a_r7_wdt_after_marker: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_req) |-> $past(scratch_we));

    a_r8_clear_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        cause_clr |=> done);
endmodule

bind rollback_guard rollback_guard_chk #(
    .OFF_W  (OFF_W),
    .OFF_LO (OFF_LO),
    .OFF_HI (OFF_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pgm_en     (pgm_en),
    .pgm_req    (pgm_req),
    .pgm_off    (pgm_off),
    .scratch_we (scratch_we),
    .wdt_req    (wdt_req),
    .cause_clr  (cause_clr),
    .panic      (panic),
    .done       (done)
);

// File: tb/rollback_guard_tb.sv
module rollback_guard_tb;
    localparam int FUSE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        ver_idx = '0;
    logic [1:0]        unit_cfg = '0;
    logic [FUSE_W-1:0] fuse_word = '0;
    logic [1:0]        rst_cause = '0;
    logic [7:0]        scratch_rd = '0;
    logic              pgm_en, pgm_req, scratch_we, wdt_req, cause_clr, panic, done;
    logic [7:0]        pgm_off, scratch_wdata;
    logic [FUSE_W-1:0] pgm_data;

    int checks = 0;
    int fails  = 0;

    int n_req, n_scr, n_clr, en_lead, en_at_scr;
    logic [7:0]        off0, off1, scr_val;
    logic [FUSE_W-1:0] dat0, dat1;

    always #5 clk = ~clk;

    rollback_guard u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ver_idx(ver_idx),
        .unit_cfg(unit_cfg), .fuse_word(fuse_word), .rst_cause(rst_cause),
        .scratch_rd(scratch_rd), .pgm_en(pgm_en), .pgm_req(pgm_req),
        .pgm_off(pgm_off), .pgm_data(pgm_data), .scratch_we(scratch_we),
        .scratch_wdata(scratch_wdata), .wdt_req(wdt_req), .cause_clr(cause_clr),
        .panic(panic), .done(done)
    );

    always @(negedge clk) begin
        if (pgm_en && !pgm_req && n_req == 0) en_lead++;
        if (pgm_req) begin
            if (n_req == 0) begin off0 = pgm_off; dat0 = pgm_data; end
            if (n_req == 1) begin off1 = pgm_off; dat1 = pgm_data; end
            n_req++;
        end
        if (scratch_we) begin
            n_scr++;
            scr_val = scratch_wdata;
            if (pgm_en) en_at_scr++;
        end
        if (cause_clr) n_clr++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        n_req = 0; n_scr = 0; n_clr = 0; en_lead = 0; en_at_scr = 0;
        off0 = '0; off1 = '0; dat0 = '0; dat1 = '0; scr_val = '0;
    endtask

    task automatic boot(input logic [1:0] v, input logic [1:0] cfg,
                        input logic [FUSE_W-1:0] fw, input logic [1:0] cause,
                        input logic [7:0] scr);
        do_reset();
        @(negedge clk);
        ver_idx = v; unit_cfg = cfg; fuse_word = fw; rst_cause = cause; scratch_rd = scr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (panic || done || wdt_req) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_done(input string req);
        chk(done === 1'b1, req, done, 1);
        chk(panic === 1'b0 && wdt_req === 1'b0, req, {panic, wdt_req}, 0);
        chk(n_req == 0 && n_scr == 0, req, n_req + n_scr, 0);
    endtask

    task automatic expect_burn(input string req, input logic [FUSE_W-1:0] pat);
        chk(n_req == 2, req, n_req, 2);
        chk(off0 == 8'h3A && off1 == 8'h3C, req, {off0, off1}, 16'h3A3C);
        chk(dat0 == pat && dat1 == pat, req, dat0, pat);
        chk(en_lead == 1, req, en_lead, 1);
        chk(n_scr == 1 && scr_val == 8'h21 && en_at_scr == 0, "R7", scr_val, 8'h21);
        chk(wdt_req === 1'b1 && panic === 1'b0 && done === 1'b0, "R7", wdt_req, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk({panic, done, wdt_req, pgm_en, pgm_req, scratch_we, cause_clr} == 0, "R1",
            {panic, done, wdt_req, pgm_en, pgm_req, scratch_we, cause_clr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({panic, done, wdt_req, pgm_en, scratch_we} == 0, "R1 idle",
            {panic, done, wdt_req, pgm_en, scratch_we}, 0);
    endtask

    task automatic t_match_scattered();
        boot(2'd2, 2'd0, 16'h8101, 2'd0, 8'h00); // R4: three scattered bits, R2: need 3
        expect_done("R4");
        chk(n_clr == 0, "R10", n_clr, 0);
    endtask

    task automatic t_surplus();
        boot(2'd3, 2'd0, 16'h00FF, 2'd0, 8'h00); // 8 > 4
        chk(panic === 1'b1 && n_req == 0 && n_scr == 0, "R5", panic, 1);
        fuse_word = '0; start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        chk(panic === 1'b1 && wdt_req === 1'b0 && done === 1'b0, "R5 sticky", panic, 1);
    endtask

    task automatic t_burn_prod();
        boot(2'd1, 2'd0, 16'h0001, 2'd0, 8'h00); // R2: need 2
        expect_burn("R6", 16'h0003);
    endtask

    task automatic t_burn_debug();
        boot(2'd3, 2'd3, 16'h0000, 2'd0, 8'h00); // R3: debug needs 1
        expect_burn("R3", 16'h0001);
    endtask

    task automatic t_debug_surplus();
        boot(2'd1, 2'd3, 16'h0400, 2'd0, 8'h00); // R3: debug needs 0
        chk(panic === 1'b1, "R3", panic, 1);
    endtask

    task automatic t_other_cfg();
        boot(2'd0, 2'd2, 16'h0000, 2'd0, 8'h00); // R3: non-production needs 0
        expect_done("R3");
    endtask

    task automatic t_prod_v3_burn();
        boot(2'd3, 2'd0, 16'h0003, 2'd0, 8'h00); // R2: need 4
        expect_burn("R2", 16'h000F);
    endtask

    task automatic t_post_burn_ok();
        boot(2'd1, 2'd0, 16'h0003, 2'd1, 8'h21);
        chk(n_clr == 1, "R8", n_clr, 1);
        chk(done === 1'b1 && n_req == 0, "R8", done, 1);
    endtask

    task automatic t_post_burn_short();
        boot(2'd3, 2'd0, 16'h0007, 2'd1, 8'h21);
        chk(panic === 1'b1, "R9", panic, 1);
        chk(n_req == 0 && n_clr == 0 && n_scr == 0, "R9", n_req + n_clr + n_scr, 0);
    endtask

    task automatic t_wdt_no_marker();
        boot(2'd0, 2'd0, 16'h4000, 2'd1, 8'h00);
        expect_done("R10");
        chk(n_clr == 0, "R10", n_clr, 0);
    endtask

    task automatic t_done_locked();
        boot(2'd0, 2'd0, 16'h0001, 2'd0, 8'h00);
        fuse_word = 16'hFFFF; start = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done === 1'b1 && panic === 1'b0, "R11", {done, panic}, 2);
        chk(n_req == 0 && n_scr == 0, "R11", n_req, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_match_scattered();
        t_surplus();
        t_burn_prod();
        t_burn_debug();
        t_debug_surplus();
        t_other_cfg();
        t_prod_v3_burn();
        t_post_burn_ok();
        t_post_burn_short();
        t_wdt_no_marker();
        t_done_locked();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule